// File: doc/BRIEF.md
# Command-Queued SPI Master

This block is an SPI master with a register interface on the host side. Software pushes 32-bit command words into a four-entry transmit queue. Each word carries up to 16 data bits in its low half. Its high half holds three control fields:

- a one-hot chip-select field;
- an index that picks one of two attribute sets;
- a continuation flag.

When the block is not halted, the engine takes the oldest entry and shifts it out on `sck`/`mosi` while it samples `miso`. It then places the received word in a four-entry receive queue. Because every frame returns a word, software matches each read with a push. When it only wants to receive, it pushes idle data of zero.

Each attribute set defines the following:

- the frame length, as the bit count minus one;
- the clock polarity;
- the clock phase;
- the bit order;
- an 8-bit half-period count that sets the serial clock rate.

Each of the six chip selects has its own programmable idle level. A continuation flag keeps the select asserted after its frame ends, so that multi-frame transactions are possible. A halt bit keeps new frames from starting while software reconfigures the block. Two self-clearing bits empty the two queues.

Register map (word addresses on `regAddr`):

| Address | Register |
|---|---|
| 0 | control |
| 1 | status |
| 2 | push |
| 3 | pop |
| 4 | attribute set 0 |
| 5 | attribute set 1 |

A pop is performed by a read of address 3 with `regRe` high.

Top module: `spiq_master`

## Requirements
- R1: After reset, the control register reads 0x3F: all idle-level bits are 1 and halt is 0. Status reads 0x100. Every `csOut` line is high, `sck` is low and attribute set 0 reads 0x0007.
- R2: A push word holds the following fields. A frame uses the attribute set selected by the index, and during the frame only the selected chip-select line leaves its idle level.

  | Bits | Field |
  |---|---|
  | [15:0] | data |
  | [21:16] | one-hot chip select |
  | [24] | attribute-set index |
  | [31] | continuation flag |
- R3: The transmit queue holds 4 entries. A push to a full queue is dropped and sets the sticky overflow flag (status bit 9). The flag stays set until a transmit flush.
- R4: The status register has the following fields.

  | Bits | Field |
  |---|---|
  | [2:0] | transmit entry count |
  | [6:4] | receive entry count |
  | [8] | running, which is 1 whenever halt is 0 |
  | [9] | overflow |
  | [10] | engine busy |
- R5: If an entry has the continuation flag set, its chip select stays asserted after its frame, even when the queue runs empty. A frame with the flag clear returns the select to its idle level when the frame ends.
- R6: Control bits [5:0] give the idle level of each chip select. A select shows that level while it is not in use and the opposite level while it is asserted.
- R7: While halt (control bit 8) is 1, no frame starts, and queued entries and all chip selects stay idle. Clearing the bit lets queued entries go out in order.
- R8: Writing 1 to control bit 9 empties the transmit queue and clears overflow. Writing 1 to bit 10 empties the receive queue. Both bits read back as 0.
- R9: The attribute register has the following layout. A frame has frame-length + 1 bits, and half-period count + 1 clocks pass between serial clock edges.

  | Bits | Field |
  |---|---|
  | [3:0] | frame length (bit count minus one) |
  | [4] | CPOL |
  | [5] | CPHA |
  | [6] | LSB-first |
  | [15:8] | half-period count |
- R10: `sck` idles at CPOL. When CPHA is 0, data is sampled on leading edges and changes on trailing edges. When CPHA is 1, data changes on leading edges after the first one and is sampled on trailing edges.
- R11: With LSB-first at 0, the most significant bit of the frame goes out first. With LSB-first at 1, bit 0 goes out first. Received bits are assembled in the same order.
- R12: Each completed frame adds one entry to the receive queue. A pop returns the oldest received word in bits [15:0]. A pop of an empty queue returns 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (pops the receive queue at address 3) |
| regAddr | input | 3 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csOut | output | NUM_CS | Chip-select lines, each with a programmable idle level |

## Verification
The assertions assume the following about the inputs:

- The chip-select field of every pushed word has at most one bit set.
- At most one register access happens per cycle.
- The frame-length field is never changed by a write to an attribute set while a frame that uses it is in flight.

The stimulus pushes only one-hot selects and changes attribute sets only when both queues are drained. It reaches the halted, full and continued states by ordered register writes, never by overlapping accesses.

// File: rtl/spiq_pkg.sv
package spiq_pkg;

  localparam int CS_FIELD_W = 8;
  localparam int NUM_ATTR = 2;
  localparam int ATTR_IDX_W = $clog2(NUM_ATTR);

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_STAT = 3'd1;
  localparam logic [2:0] ADDR_PUSH = 3'd2;
  localparam logic [2:0] ADDR_POP  = 3'd3;

  localparam int CTRL_HALT     = 8;
  localparam int CTRL_FLUSH_TX = 9;
  localparam int CTRL_FLUSH_RX = 10;
  localparam int PUSH_CS_LSB   = 16;
  localparam int PUSH_ATTR_LSB = 24;
  localparam int PUSH_CONT     = 31;

  typedef struct packed {
    logic [7:0] halfDiv;
    logic       spare;
    logic       lsbFirst;
    logic       cpha;
    logic       cpol;
    logic [3:0] frameLen;
  } spiqAttr_t;

  typedef struct packed {
    logic                  load;
    logic                  cont;
    logic [CS_FIELD_W-1:0] csSel;
    spiqAttr_t             attr;
    logic [15:0]           data;
  } spiqStrobe_t;

endpackage

// File: rtl/spiq_ctrl.sv
module spiq_ctrl
  import spiq_pkg::*;
#(
  parameter int NUM_CS   = 6,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              dpBusy,
  input  logic              dpDone,
  input  logic [15:0]       dpRxWord,
  output spiqStrobe_t       strobe,
  output logic [NUM_CS-1:0] inactiveLvl
);

  localparam int TXP_W = $clog2(TX_DEPTH);
  localparam int TXC_W = $clog2(TX_DEPTH + 1);
  localparam int RXP_W = $clog2(RX_DEPTH);
  localparam int RXC_W = $clog2(RX_DEPTH + 1);

  logic              halt;
  logic              overflow;
  logic [31:0]       txMem [TX_DEPTH];
  logic [TXP_W-1:0]  txRd, txWr;
  logic [TXC_W-1:0]  txCount;
  logic [15:0]       rxMem [RX_DEPTH];
  logic [RXP_W-1:0]  rxRd, rxWr;
  logic [RXC_W-1:0]  rxCount;
  spiqAttr_t         attrReg [NUM_ATTR];

  logic ctrlWr, flushTx, flushRx, pushReq, pushOk, loadNow, popReq, rxPush;
  logic [31:0] head;

  assign ctrlWr  = regWe && (regAddr == ADDR_CTRL);
  assign flushTx = ctrlWr && regWdata[CTRL_FLUSH_TX];
  assign flushRx = ctrlWr && regWdata[CTRL_FLUSH_RX];
  assign pushReq = regWe && (regAddr == ADDR_PUSH);
  assign pushOk  = pushReq && (txCount != TXC_W'(TX_DEPTH));
  assign loadNow = !halt && !dpBusy && (txCount != '0) && !flushTx;
  assign popReq  = regRe && (regAddr == ADDR_POP) && (rxCount != '0);
  assign rxPush  = dpDone && (rxCount != RXC_W'(RX_DEPTH)) && !flushRx;
  assign head    = txMem[txRd];

  // Control register and sticky overflow flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halt        <= 1'b0;
      inactiveLvl <= '1;
      overflow    <= 1'b0;
    end else begin
      if (ctrlWr) begin
        halt        <= regWdata[CTRL_HALT];
        inactiveLvl <= regWdata[NUM_CS-1:0];
      end
      if (flushTx)                  overflow <= 1'b0;
      else if (pushReq && !pushOk)  overflow <= 1'b1;
    end
  end

  // Attribute sets, one register per set
  for (genvar g = 0; g < NUM_ATTR; g++) begin : gAttr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) attrReg[g] <= spiqAttr_t'(16'h0007);
      else if (regWe && regAddr[2] && (regAddr[ATTR_IDX_W-1:0] == ATTR_IDX_W'(g)))
        attrReg[g] <= spiqAttr_t'(regWdata[15:0]);
    end
  end

  // Transmit queue
  always_ff @(posedge clk) if (pushOk) txMem[txWr] <= regWdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txRd <= '0; txWr <= '0; txCount <= '0;
    end else if (flushTx) begin
      txRd <= '0; txWr <= '0; txCount <= '0;
    end else begin
      if (pushOk)  txWr <= txWr + 1'b1;
      if (loadNow) txRd <= txRd + 1'b1;
      txCount <= txCount + TXC_W'(pushOk) - TXC_W'(loadNow);
    end
  end

  // Receive queue
  always_ff @(posedge clk) if (rxPush) rxMem[rxWr] <= dpRxWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxRd <= '0; rxWr <= '0; rxCount <= '0;
    end else if (flushRx) begin
      rxRd <= '0; rxWr <= '0; rxCount <= '0;
    end else begin
      if (rxPush) rxWr <= rxWr + 1'b1;
      if (popReq) rxRd <= rxRd + 1'b1;
      rxCount <= rxCount + RXC_W'(rxPush) - RXC_W'(popReq);
    end
  end

  // Strobes toward the shift engine
  always_comb begin
    strobe.load  = loadNow;
    strobe.cont  = head[PUSH_CONT];
    strobe.csSel = head[PUSH_CS_LSB +: CS_FIELD_W];
    strobe.attr  = attrReg[head[PUSH_ATTR_LSB +: ATTR_IDX_W]];
    strobe.data  = head[15:0];
  end

  // Register read mux
  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_CTRL: begin
        regRdata[NUM_CS-1:0] = inactiveLvl;
        regRdata[CTRL_HALT]  = halt;
      end
      ADDR_STAT: begin
        regRdata[2:0] = 3'(txCount);
        regRdata[6:4] = 3'(rxCount);
        regRdata[8]   = !halt;
        regRdata[9]   = overflow;
        regRdata[10]  = dpBusy;
      end
      ADDR_POP: regRdata = (rxCount == '0) ? 32'hFFFF_FFFF : {16'h0, rxMem[rxRd]};
      default:  if (regAddr[2]) regRdata = {16'h0, attrReg[regAddr[ATTR_IDX_W-1:0]]};
    endcase
  end

  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    txCount <= TXC_W'(TX_DEPTH)); // R3
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && txCount == TXC_W'(TX_DEPTH) && !flushTx) |=> overflow); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !flushTx) |=> overflow); // R3
  AST_HALT_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (halt && !dpBusy) |=> !dpBusy); // R7
  AST_FLUSH_TX: assert property (@(posedge clk) disable iff (!rstN)
    flushTx |=> (txCount == '0)); // R8
  AST_RX_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    (dpDone && rxCount != RXC_W'(RX_DEPTH) && !popReq && !flushRx)
      |=> (rxCount == RXC_W'($past(rxCount) + 1'b1))); // R12

endmodule

// File: rtl/spiq_engine.sv
module spiq_engine
  import spiq_pkg::*;
#(
  parameter int NUM_CS = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiqStrobe_t       strobe,
  input  logic [NUM_CS-1:0] inactiveLvl,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic [NUM_CS-1:0] csOut,
  output logic              busy,
  output logic              done,
  output logic [15:0]       rxWord
);

  localparam int EDGE_W = 6;

  spiqAttr_t         attrL;
  logic              contL;
  logic [NUM_CS-1:0] csActive;
  logic [7:0]        divCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic              sckLvl;
  logic [15:0]       txSh, rxSh;

  logic [EDGE_W-1:0] lastEdge;
  logic tick, leading, sampleNow, shiftNow;

  assign lastEdge  = EDGE_W'({attrL.frameLen, 1'b0}) + EDGE_W'(2);
  assign tick      = busy && (divCnt == attrL.halfDiv);
  assign leading   = !edgeCnt[0];
  assign sampleNow = tick && (edgeCnt != lastEdge) && (leading ^ attrL.cpha);
  assign shiftNow  = tick && (edgeCnt != lastEdge) && !(leading ^ attrL.cpha)
                     && (edgeCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      attrL    <= spiqAttr_t'(16'h0007);
      contL    <= 1'b0;
      csActive <= '0;
      divCnt   <= '0;
      edgeCnt  <= '0;
      sckLvl   <= 1'b0;
      txSh     <= '0;
      rxSh     <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      rxWord   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (strobe.load) begin
          busy     <= 1'b1;
          attrL    <= strobe.attr;
          contL    <= strobe.cont;
          csActive <= strobe.csSel[NUM_CS-1:0];
          divCnt   <= '0;
          edgeCnt  <= '0;
          sckLvl   <= 1'b0;
          rxSh     <= '0;
          txSh     <= strobe.attr.lsbFirst ? strobe.data
                      : (strobe.data << (4'd15 - strobe.attr.frameLen));
        end
      end else if (tick) begin
        divCnt <= '0;
        if (edgeCnt == lastEdge) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          rxWord <= attrL.lsbFirst ? (rxSh >> (4'd15 - attrL.frameLen)) : rxSh;
          if (!contL) csActive <= '0;
        end else begin
          edgeCnt <= edgeCnt + 1'b1;
          sckLvl  <= ~sckLvl;
        end
        if (sampleNow) rxSh <= attrL.lsbFirst ? {miso, rxSh[15:1]} : {rxSh[14:0], miso};
        if (shiftNow)  txSh <= attrL.lsbFirst ? (txSh >> 1) : (txSh << 1);
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign sck  = attrL.cpol ^ sckLvl;
  assign mosi = attrL.lsbFirst ? txSh[0] : txSh[15];

  for (genvar i = 0; i < NUM_CS; i++) begin : gCs
    assign csOut[i] = csActive[i] ? ~inactiveLvl[i] : inactiveLvl[i];
  end

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> $onehot0(csActive)); // R2
  AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && !contL) |-> (csActive == '0)); // R5
  AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (edgeCnt <= lastEdge)); // R9
  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (sck == attrL.cpol)); // R10

endmodule

// File: rtl/spiq_master.sv
module spiq_master
  import spiq_pkg::*;
#(
  parameter int NUM_CS   = 6,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] csOut
);

  spiqStrobe_t       strobe;
  logic [NUM_CS-1:0] inactiveLvl;
  logic              dpBusy, dpDone;
  logic [15:0]       dpRxWord;

  spiq_ctrl #(.NUM_CS(NUM_CS), .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .dpBusy(dpBusy), .dpDone(dpDone),
    .dpRxWord(dpRxWord), .strobe(strobe), .inactiveLvl(inactiveLvl)
  );

  spiq_engine #(.NUM_CS(NUM_CS)) u_engine (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inactiveLvl(inactiveLvl),
    .miso(miso), .sck(sck), .mosi(mosi), .csOut(csOut), .busy(dpBusy),
    .done(dpDone), .rxWord(dpRxWord)
  );

endmodule

// File: tb/spiq_master_bench.sv
module spiq_master_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_VEC = 8;
  // fields: [15:0] data, [19:16] frame length, [20] cpol, [21] cpha,
  //         [22] lsb first, [23] invert miso, [26:24] chip select index
  localparam logic [31:0] VEC [NUM_VEC] = '{
    32'h0007_00A5, 32'h0117_003C, 32'h0227_0096, 32'h0377_005A,
    32'h04CF_BEEF, 32'h052F_12C3, 32'h00D3_000B, 32'h013B_0ABC
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0, regRe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        sck, mosi, miso;
  logic [5:0]  csOut;

  logic        misoInv = 1'b0;
  logic        cpolMon = 1'b0, cphaMon = 1'b0, seenLeading = 1'b0;
  logic [15:0] capBits = '0;
  int          capCnt = 0;
  logic [5:0]  inactiveMon = 6'h3F, csSeen = '0, prevCs = 6'h3F;
  int          relCount = 0;
  int          checks = 0, errors = 0;
  bit          finished = 1'b0;

  assign miso = mosi ^ misoInv;

  always #(CLK_PERIOD/2) clk = ~clk;

  spiq_master u_spiq_master (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sck(sck), .mosi(mosi),
    .miso(miso), .csOut(csOut)
  );

  // serial monitor: skips an idle-level jump, then takes bits on sampling edges
  always @(sck) begin
    if (rstN === 1'b1) begin
      if (sck !== cpolMon) begin
        seenLeading = 1'b1;
        if (!cphaMon) begin capBits = {capBits[14:0], mosi}; capCnt++; end
      end else if (seenLeading) begin
        seenLeading = 1'b0;
        if (cphaMon) begin capBits = {capBits[14:0], mosi}; capCnt++; end
      end
    end
  end

  always @(csOut) begin
    if (rstN === 1'b1) begin
      for (int i = 0; i < 6; i++)
        if (prevCs[i] != inactiveMon[i] && csOut[i] == inactiveMon[i]) relCount++;
      csSeen = csSeen | (csOut ^ inactiveMon);
    end
    prevCs = csOut;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRe = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRe = 1'b0;
  endtask

  task automatic waitRx(input int n);
    logic [31:0] s;
    for (int k = 0; k < 3000; k++) begin
      regRead(3'd1, s);
      if (int'(s[6:4]) == n && !s[10]) break;
    end
  endtask

  function automatic logic [15:0] rev(input logic [15:0] d, input int n);
    logic [15:0] r = '0;
    for (int k = 0; k < n; k++) r[n-1-k] = d[k];
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    #1;
    chk("R1 cs idle", 32'(csOut), 32'h3F);
    chk("R1 sck idle", 32'(sck), 32'h0);
    regRead(3'd0, r); chk("R1 ctrl", r, 32'h3F);
    regRead(3'd1, r); chk("R1/R4 status", r, 32'h100);
    regRead(3'd4, r); chk("R1/R9 attr0", r, 32'h0007);
    regRead(3'd3, r); chk("R12 empty pop", r, 32'hFFFF_FFFF);

    // vector table: modes, sizes, bit orders, selects
    for (int v = 0; v < NUM_VEC; v++) begin
      logic [15:0] d, mask, expRx, expSer;
      int n, csI;
      logic cpol, cpha, lsb, inv;
      d = VEC[v][15:0]; n = int'(VEC[v][19:16]) + 1;
      cpol = VEC[v][20]; cpha = VEC[v][21]; lsb = VEC[v][22]; inv = VEC[v][23];
      csI = int'(VEC[v][26:24]);
      mask = 16'((32'h1 << n) - 1);
      expRx = (inv ? ~d : d) & mask;
      expSer = lsb ? rev(d, n) : (d & mask);
      regWrite(3'd4, {16'h0, 8'(v % 3), 1'b0, lsb, cpha, cpol, VEC[v][19:16]});
      misoInv = inv; cpolMon = cpol; cphaMon = cpha;
      @(negedge clk);
      capCnt = 0; capBits = '0; csSeen = '0; seenLeading = 1'b0;
      regWrite(3'd2, (32'h1 << (16 + csI)) | {16'h0, d});
      waitRx(1);
      chk("R9 bit count", 32'(capCnt), 32'(n));
      chk("R10/R11 serial order", 32'(capBits & mask), 32'(expSer));
      chk("R2 select", 32'(csSeen), 32'h1 << csI);
      chk("R10 sck idle", 32'(sck), 32'(cpol));
      regRead(3'd3, r); chk("R12 rx word", r, 32'(expRx));
    end
    misoInv = 1'b0; cpolMon = 1'b0; cphaMon = 1'b0;
    regWrite(3'd4, 32'h0007);

    // R7 halt and R3 overflow
    regWrite(3'd0, 32'h13F);
    for (int k = 0; k < 5; k++) regWrite(3'd2, 32'h0001_0010 + 32'(k));
    regRead(3'd1, r); chk("R3 full + overflow", r, 32'h204);
    repeat (60) @(negedge clk);
    regRead(3'd1, r); chk("R7 halted no start", r, 32'h204);
    chk("R7 cs idle", 32'(csOut), 32'h3F);
    regWrite(3'd0, 32'h3F);
    waitRx(4);
    regRead(3'd1, r); chk("R4 status after run", r, 32'h340);
    for (int k = 0; k < 4; k++) begin
      regRead(3'd3, r); chk("R3 fifth push dropped", r, 32'h10 + 32'(k));
    end

    // R8 transmit flush
    regWrite(3'd0, 32'h13F);
    regWrite(3'd2, 32'h0001_0001);
    regWrite(3'd2, 32'h0001_0002);
    regWrite(3'd0, 32'h23F);
    regRead(3'd0, r); chk("R8 flush self-clears", r, 32'h3F);
    regRead(3'd1, r); chk("R8 tx flushed, overflow cleared", r, 32'h100);
    repeat (60) @(negedge clk);
    regRead(3'd1, r); chk("R8 nothing sent", r, 32'h100);

    // R5 continuation
    regWrite(3'd0, 32'h13F);
    regWrite(3'd2, 32'h8001_0011);
    regWrite(3'd2, 32'h0001_0022);
    relCount = 0;
    regWrite(3'd0, 32'h3F);
    waitRx(2);
    chk("R5 one release for pair", 32'(relCount), 32'h1);
    regRead(3'd3, r); chk("R5 rx first", r, 32'h11);
    regRead(3'd3, r); chk("R5 rx second", r, 32'h22);
    regWrite(3'd2, 32'h8001_0033);
    waitRx(1);
    chk("R5 held after frame", 32'(csOut), 32'h3E);
    regWrite(3'd2, 32'h0001_0044);
    waitRx(2);
    chk("R5 released", 32'(csOut), 32'h3F);
    regRead(3'd3, r); regRead(3'd3, r); chk("R12 order", r, 32'h44);

    // R6 idle-low select
    inactiveMon = 6'h3B;
    regWrite(3'd0, 32'h3B);
    @(negedge clk);
    chk("R6 idle low", 32'(csOut), 32'h3B);
    relCount = 0; csSeen = '0;
    regWrite(3'd2, 32'h0004_0055);
    waitRx(1);
    chk("R6 asserted high once", 32'(relCount), 32'h1);
    chk("R6 select seen", 32'(csSeen), 32'h04);
    chk("R6 back to idle", 32'(csOut), 32'h3B);
    regRead(3'd3, r); chk("R12 rx idle-low frame", r, 32'h55);
    inactiveMon = 6'h3F;
    regWrite(3'd0, 32'h3F);

    // R2/R9 attribute set select
    regWrite(3'd5, 32'h014F);
    regRead(3'd5, r); chk("R9 attr1 readback", r, 32'h014F);
    @(negedge clk);
    capCnt = 0; capBits = '0; seenLeading = 1'b0;
    regWrite(3'd2, 32'h0102_8003);
    waitRx(1);
    chk("R2 attr1 frame length", 32'(capCnt), 32'd16);
    chk("R11 lsb first via attr1", 32'(capBits), 32'hC001);
    regRead(3'd3, r); chk("R12 rx attr1", r, 32'h8003);

    // R8 receive flush
    regWrite(3'd2, 32'h0001_0066);
    regWrite(3'd2, 32'h0001_0077);
    waitRx(2);
    regWrite(3'd0, 32'h43F);
    regRead(3'd1, r); chk("R8 rx flushed", r, 32'h100);
    regRead(3'd3, r); chk("R12 pop after flush", r, 32'hFFFF_FFFF);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule